// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits between a 32-bit register bus and the shift engine of a SPI master. It holds a transmit FIFO and a receive FIFO, each of `DEPTH` bytes. Software loads transmit data one 32-bit word at a time. The shift engine takes those bytes one at a time from the transmit side. The engine hands received bytes back one at a time, and software drains them either as whole words or, for a trailing remainder, as single bytes. The access width of the read selects which.

A status word reports whether the receive side holds data, whether the transmit side can take another word, a sticky transmit-overflow flag, and live byte counts for both FIFOs. A mask register picks which of the three status bits drive the interrupt line. Sticky bits are cleared by writing ones to the status word.

Top module: `spi_fifo_evt`

## Requirements
- R1: After reset the status word at offset 0x04 reads 0x00000100, the mask at 0x08 reads zero, `irq` is low, `tx_avail` is low and `rx_space` is high.
- R2: A write to offset 0x10 stores four bytes in the transmit FIFO. The shift side receives bits 31:24 first and bits 7:0 last, each presented on `tx_byte` while `tx_avail` is high and removed by `tx_pop`.
- R3: A write to 0x10 when fewer than four transmit bytes are free stores nothing, leaves the transmit count unchanged and sets the overflow flag, status bit 10.
- R4: Status bits 29:24 hold the receive byte count and bits 21:16 hold the transmit byte count. All other bits outside 10:8 read zero.
- R5: Status bit 9 is high exactly when the receive FIFO holds at least one byte. Status bit 8 is high exactly when at least four transmit bytes are free. Writing ones to these bits has no lasting effect while their condition holds.
- R6: A 32-bit read of offset 0x14 with at least four bytes stored returns the four oldest bytes, the oldest in bits 31:24, and removes them.
- R7: An 8-bit read of offset 0x14 with at least one byte stored returns the oldest byte in bits 7:0 with bits 31:8 zero, and removes only that byte.
- R8: An 8-bit read of 0x14 from an empty receive FIFO, or a 32-bit read with fewer than four bytes stored, returns zero and removes nothing.
- R9: Writing a one to status bit 10 clears the overflow flag; writing all ones clears every sticky bit.
- R10: The mask at 0x08 keeps bits 10:8 and reads zero elsewhere. `irq` is high exactly when some status bit among 10:8 and its mask bit are both set.
- R11: When the receive FIFO holds `DEPTH` bytes, `rx_space` is low and a push is dropped. A `tx_pop` with the transmit FIFO empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access cycle |
| irq | output | 1 | Masked interrupt request |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit FIFO holds a byte |
| tx_pop | input | 1 | Shift engine takes `tx_byte` |
| rx_byte | input | 8 | Byte from the shift engine |
| rx_push | input | 1 | Store `rx_byte` |
| rx_space | output | 1 | Receive FIFO can accept a byte |

## Verification
Read data is combinational in the access cycle. The bench therefore samples `bus_rdata` mid-cycle, after driving the access at the falling edge and before the rising edge that performs the pop. FIFO counts, status bits, `tx_byte`, `tx_avail`, `rx_space` and `irq` all change at the rising edge that ends a push, pop or write. They are due one cycle later, so every check of them is made at or after the next falling edge. The bench keeps byte queues as its model, and each expected value is computed from the bytes it has pushed and the widths of its reads.

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt #(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_wr,
  input  logic        bus_word,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic [7:0]  tx_byte,
  output logic        tx_avail,
  input  logic        tx_pop,
  input  logic [7:0]  rx_byte,
  input  logic        rx_push,
  output logic        rx_space
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [7:0] A_EVT = 8'h04;
  localparam logic [7:0] A_MSK = 8'h08;
  localparam logic [7:0] A_TXD = 8'h10;
  localparam logic [7:0] A_RXD = 8'h14;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          ovf;
  logic [2:0]    mask_q;

  wire rd     = bus_en & ~bus_wr;
  wire wr     = bus_en & bus_wr;
  wire tx_wr  = wr & (bus_addr == A_TXD);
  wire ev_wr  = wr & (bus_addr == A_EVT);
  wire msk_wr = wr & (bus_addr == A_MSK);
  wire rx_rd  = rd & (bus_addr == A_RXD);

  wire tx_room = tx_cnt <= CW'(DEPTH - 4);
  wire tx_push = tx_wr & tx_room;
  wire tx_take = tx_pop & (tx_cnt != '0);
  wire rx_take_w = rx_rd & bus_word & (rx_cnt >= CW'(4));
  wire rx_take_b = rx_rd & ~bus_word & (rx_cnt != '0);
  wire rx_in     = rx_push & (rx_cnt != CW'(DEPTH));

  wire rne = rx_cnt != '0;
  wire tnf = tx_room;
  wire [2:0] evt_bits = {ovf, rne, tnf};

  logic [5:0] rx_cnt6, tx_cnt6;
  assign rx_cnt6 = 6'(rx_cnt);
  assign tx_cnt6 = 6'(tx_cnt);

  always_ff @(posedge clk) begin
    if (tx_push)
      for (int i = 0; i < 4; i++)
        tx_mem[tx_wp + AW'(i)] <= bus_wdata[31 - 8*i -: 8];
    if (rx_in)
      rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(4);
      if (tx_take) tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + (tx_push ? CW'(4) : CW'(0)) - (tx_take ? CW'(1) : CW'(0));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_in) rx_wp <= rx_wp + AW'(1);
      if (rx_take_w) rx_rp <= rx_rp + AW'(4);
      else if (rx_take_b) rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + (rx_in ? CW'(1) : CW'(0))
                - (rx_take_w ? CW'(4) : (rx_take_b ? CW'(1) : CW'(0)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf    <= 1'b0;
      mask_q <= '0;
    end else begin
      if (tx_wr && !tx_room) ovf <= 1'b1;
      else if (ev_wr && bus_wdata[10]) ovf <= 1'b0;
      if (msk_wr) mask_q <= bus_wdata[10:8];
    end
  end

  logic [31:0] rx_word;
  always_comb begin
    rx_word = '0;
    if (rx_take_w)
      for (int i = 0; i < 4; i++)
        rx_word[31 - 8*i -: 8] = rx_mem[rx_rp + AW'(i)];
    else if (rx_take_b)
      rx_word[7:0] = rx_mem[rx_rp];
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_EVT: bus_rdata = {2'b00, rx_cnt6, 2'b00, tx_cnt6, 5'b0, evt_bits, 8'h00};
        A_MSK: bus_rdata = {21'b0, mask_q, 8'h00};
        A_RXD: bus_rdata = rx_word;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq      = |(evt_bits & mask_q);
  assign tx_byte  = tx_mem[tx_rp];
  assign tx_avail = tx_cnt != '0;
  assign rx_space = rx_cnt != CW'(DEPTH);
endmodule

module spi_fifo_evt_chk #(
  parameter int DEPTH = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_wr,
  input logic          bus_word,
  input logic [7:0]    bus_addr,
  input logic          tx_pop,
  input logic          rx_push,
  input logic          rx_space,
  input logic          irq,
  input logic          ovf,
  input logic [2:0]    mask_q,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  wire txw = bus_en && bus_wr && bus_addr == 8'h10;
  wire rxr = bus_en && !bus_wr && bus_addr == 8'h14;

  // R2
  tx_push_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txw && int'(tx_cnt) <= DEPTH - 4 && !tx_pop) |=> int'(tx_cnt) == int'($past(tx_cnt)) + 4);
  // R3
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txw && int'(tx_cnt) > DEPTH - 4 && !tx_pop) |=> ($stable(tx_cnt) && ovf));
  // R8
  rx_short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxr && bus_word && int'(rx_cnt) < 4 && !rx_push) |=> $stable(rx_cnt));
  // R7
  rx_byte_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxr && !bus_word && rx_cnt != '0 && !rx_push) |=> int'(rx_cnt) == int'($past(rx_cnt)) - 1);
  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 3'b000) |-> !irq);
  // R11
  rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_cnt) == DEPTH) |-> !rx_space);
endmodule

bind spi_fifo_evt spi_fifo_evt_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_word(bus_word),
  .bus_addr(bus_addr), .tx_pop(tx_pop), .rx_push(rx_push), .rx_space(rx_space),
  .irq(irq), .ovf(ovf), .mask_q(mask_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_fifo_evt_tb.sv
module spi_fifo_evt_tb;
  localparam int DEPTH = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_wr = 0, bus_word = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, tx_avail, rx_space;
  logic [7:0] tx_byte;
  logic tx_pop = 0, rx_push = 0;
  logic [7:0] rx_byte = '0;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_fifo_evt #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_word = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic w, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_word = w; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic rxp(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1; rx_byte = b;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic txp(output logic [7:0] b);
    @(negedge clk);
    b = tx_byte; tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
  endtask

  function automatic logic [31:0] evt(input int rc, input int tc, input bit ov);
    return {2'b00, 6'(rc), 2'b00, 6'(tc), 5'b0, ov, rc != 0, tc <= DEPTH - 4, 8'h00};
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] b;
    int rem, base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(8'h04, 1, d); chk(d, 32'h0000_0100, "R1 event");
    rd(8'h08, 1, d); chk(d, 0, "R1 mask");
    chk(irq, 0, "R1 irq"); chk(tx_avail, 0, "R1 tx_avail"); chk(rx_space, 1, "R1 rx_space");

    // R2 R3 R4 R5: fill the transmit side word by word, one past full
    for (int k = 0; k <= DEPTH / 4; k++) begin
      wr(8'h10, {8'(4*k), 8'(4*k+1), 8'(4*k+2), 8'(4*k+3)});
      rd(8'h04, 1, d);
      chk(d, evt(0, (k + 1) * 4 > DEPTH ? DEPTH : (k + 1) * 4, (k + 1) * 4 > DEPTH),
          "R4 R5 R3 tx fill event");
    end
    for (int i = 0; i < DEPTH; i++) begin
      txp(b); chk(b, 8'(i), "R2 tx byte order");
    end
    chk(tx_avail, 0, "R11 tx empty");
    txp(b);
    rd(8'h04, 1, d); chk(d, evt(0, 0, 1), "R11 pop on empty ignored");

    // R9 R5: clear overflow; live bit survives an all-ones write
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 1, d); chk(d, 32'h0000_0100, "R9 R5 clear");

    // R6 R7 R8: sweep receive fill levels
    for (int n = 0; n < 10; n++) begin
      for (int i = 0; i < n; i++) rxp(8'((n << 4) | i));
      rd(8'h04, 1, d); chk(d, evt(n, 0, 0), "R4 R5 rx count");
      rem = n; base = 0;
      while (rem >= 4) begin
        rd(8'h14, 1, d);
        chk(d, {8'((n<<4)|base), 8'((n<<4)|(base+1)), 8'((n<<4)|(base+2)), 8'((n<<4)|(base+3))},
            "R6 word pop");
        rem -= 4; base += 4;
      end
      if (rem > 0) begin
        rd(8'h14, 1, d); chk(d, 0, "R8 short word read");
        rd(8'h04, 1, d); chk(d, evt(rem, 0, 0), "R8 count kept");
      end
      while (rem > 0) begin
        rd(8'h14, 0, d); chk(d, {24'h0, 8'((n<<4)|base)}, "R7 byte pop");
        rem--; base++;
      end
      rd(8'h14, 0, d); chk(d, 0, "R8 empty byte read");
      rd(8'h04, 1, d); chk(d, evt(0, 0, 0), "R7 drained");
    end

    // R11: receive side full
    for (int i = 0; i <= DEPTH; i++) rxp(8'(i + 100));
    chk(rx_space, 0, "R11 rx_space");
    rd(8'h04, 1, d); chk(d, evt(DEPTH, 0, 0), "R11 rx count capped");
    for (int k = 0; k < DEPTH / 4; k++) begin
      rd(8'h14, 1, d);
      chk(d, {8'(4*k+100), 8'(4*k+101), 8'(4*k+102), 8'(4*k+103)}, "R6 full drain");
    end

    // R10: mask and irq
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 1, d); chk(d, 32'h0000_0700, "R10 mask readback");
    wr(8'h08, 32'h0000_0200);
    chk(irq, 0, "R10 rx irq idle");
    rxp(8'h5A);
    chk(irq, 1, "R10 rx irq");
    rd(8'h14, 0, d); chk(d, 32'h5A, "R7 byte");
    chk(irq, 0, "R10 rx irq cleared");
    wr(8'h08, 32'h0000_0100);
    chk(irq, 1, "R10 tx irq");
    wr(8'h08, 32'h0000_0400);
    chk(irq, 0, "R10 ovf irq idle");
    for (int k = 0; k <= DEPTH / 4; k++) wr(8'h10, 32'h0);
    chk(irq, 1, "R10 R3 ovf irq");
    wr(8'h04, 32'h0000_0400);
    chk(irq, 0, "R9 ovf cleared");
    rd(8'h04, 1, d); chk(d, evt(0, DEPTH, 0), "R9 event after clear");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule